// File: doc/BRIEF.md
# Delegating Interrupt Priority Selector

This block decides, every cycle, whether a hart has to take an interrupt and which one. It combines a pending vector and an enable vector. Each surviving bit is then gated by one of two privilege-dependent conditions: a machine-level one for bits that stay at machine level, and a supervisor-level one for bits handed down through the delegation vector. The lowest-numbered bit that passes is reported.

The selection logic is purely combinational. A parameter adds an output register stage for timing closure, so the outputs appear one clock after the inputs. The block sits between the interrupt control registers and the trap sequencer. It reads only their current values and owns no state besides the optional output stage.

Top module: `irq_sel`

## Requirements
- R1: A bit can be chosen only if it is set in both the pending vector and the enable vector. A pending bit whose enable is clear is never reported.
- R2: A non-delegated bit (delegation bit 0) passes when the privilege is U (2'b00) or S (2'b01). It also passes when the privilege is M (2'b11) and the machine enable input is 1.
- R3: With privilege M and the machine enable at 0, no non-delegated bit is reported.
- R4: A delegated bit (delegation bit 1) passes when the privilege is U. It also passes when the privilege is S and the supervisor enable input is 1.
- R5: A delegated bit is never reported when the privilege is M, whatever the enable bits are. It is also not reported when the privilege is S and the supervisor enable is 0.
- R6: Among all bits that pass, the one with the lowest index is reported on the number output, whether or not it is delegated. Index N_IRQ-1 is reachable.
- R7: When no bit passes, the take flag is 0 and the number output is 0.
- R8: With REG_OUT=1, both outputs show the selection for the inputs present at the previous rising clock edge, and hold until the next edge. With REG_OUT=0, they follow the inputs in the same cycle.
- R9: While rst_ni is low, the registered outputs are forced to take=0, number=0.
- R10: The unused privilege code 2'b10 ranks above S and below M. Non-delegated bits pass, and delegated bits are blocked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pend_i | input | N_IRQ | Pending interrupt bits |
| en_i | input | N_IRQ | Per-bit interrupt enables |
| deleg_i | input | N_IRQ | Per-bit delegation to supervisor level |
| priv_i | input | 2 | Current privilege: U=0, S=1, M=3 |
| mie_i | input | 1 | Global machine interrupt enable |
| sie_i | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | An interrupt must be taken |
| id_o | output | $clog2(N_IRQ) | Number of the chosen interrupt |

## Verification
The bench builds two copies side by side and feeds both the same stimulus. One is the default 32-bit registered build, and the other is an 8-bit combinational build that sees only the low byte. The wide registered copy reaches the top index 31 and the one-cycle lag with its hold-until-edge behaviour. The narrow copy checks same-cycle selection and a 3-bit number width. Some patterns are set so that only the bits above the low byte survive. In those cases the two copies must disagree in a known way.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [1:0] {
    PRIV_U   = 2'b00,
    PRIV_S   = 2'b01,
    PRIV_RSV = 2'b10,
    PRIV_M   = 2'b11
  } priv_e;
endpackage

// File: rtl/irq_gate.sv
module irq_gate #(
  parameter int N_IRQ = 32
) (
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] en_i,
  input  logic [N_IRQ-1:0] deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             mie_i,
  input  logic             sie_i,
  output logic [N_IRQ-1:0] surv_o
);
  import irq_sel_pkg::*;

  logic m_open, s_open;
  logic [N_IRQ-1:0] cand;

  always_comb begin
    cand   = pend_i & en_i;
    // numeric compare: reserved code 2 sits between S and M
    m_open = (priv_i < PRIV_M) || ((priv_i == PRIV_M) && mie_i);
    s_open = (priv_i < PRIV_S) || ((priv_i == PRIV_S) && sie_i);
    surv_o = cand & ((~deleg_i & {N_IRQ{m_open}}) | (deleg_i & {N_IRQ{s_open}}));
  end
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N_IRQ = 32,
  localparam int ID_W = $clog2(N_IRQ)
) (
  input  logic [N_IRQ-1:0] vec_i,
  output logic             take_o,
  output logic [ID_W-1:0]  id_o
);
  // scan downward so the lowest set bit is written last
  always_comb begin
    take_o = 1'b0;
    id_o   = '0;
    for (int i = N_IRQ - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        take_o = 1'b1;
        id_o   = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_sel.sv
module irq_sel #(
  parameter int N_IRQ   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int ID_W   = $clog2(N_IRQ)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] pend_i,
  input  logic [N_IRQ-1:0] en_i,
  input  logic [N_IRQ-1:0] deleg_i,
  input  logic [1:0]       priv_i,
  input  logic             mie_i,
  input  logic             sie_i,
  output logic             take_o,
  output logic [ID_W-1:0]  id_o
);
  import irq_sel_pkg::*;

  logic [N_IRQ-1:0] surv;
  logic             take_c;
  logic [ID_W-1:0]  id_c;

  irq_gate #(.N_IRQ(N_IRQ)) u_gate (
    .pend_i (pend_i),
    .en_i   (en_i),
    .deleg_i(deleg_i),
    .priv_i (priv_i),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .surv_o (surv)
  );

  irq_pick #(.N_IRQ(N_IRQ)) u_pick (
    .vec_i (surv),
    .take_o(take_c),
    .id_o  (id_c)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          take_o <= 1'b0;
          id_o   <= '0;
        end else begin
          take_o <= take_c;
          id_o   <= id_c;
        end
      end

      assert_reg_lag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (take_o == $past(take_c)) && (id_o == $past(id_c)));
    end else begin : g_comb
      assign take_o = take_c;
      assign id_o   = id_c;
    end
  endgenerate

  assert_idle_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_o |-> (id_o == '0));

  assert_win_enabled_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_c |-> (pend_i[id_c] && en_i[id_c]));

  assert_lowest_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_c |-> ((surv & ((N_IRQ'(1) << id_c) - N_IRQ'(1))) == '0));

  assert_m_closed_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((priv_i == PRIV_M) && !mie_i) |-> ((surv & ~deleg_i) == '0));

  assert_s_closed_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((priv_i == PRIV_M) || ((priv_i == PRIV_S) && !sie_i)) |-> ((surv & deleg_i) == '0));
endmodule

// File: tb/sim_irq_sel.sv
`timescale 1ns/1ps
module sim_irq_sel;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pend = '0, en = '0, deleg = '0;
  logic [1:0]  priv = 2'b00;
  logic        mie = 1'b0, sie = 1'b0;
  logic        take0, take1;
  logic [4:0]  id0;
  logic [2:0]  id1;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_sel #(.N_IRQ(32), .REG_OUT(1'b1)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend), .en_i(en), .deleg_i(deleg),
    .priv_i(priv), .mie_i(mie), .sie_i(sie), .take_o(take0), .id_o(id0));

  irq_sel #(.N_IRQ(8), .REG_OUT(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .pend_i(pend[7:0]), .en_i(en[7:0]),
    .deleg_i(deleg[7:0]), .priv_i(priv), .mie_i(mie), .sie_i(sie),
    .take_o(take1), .id_o(id1));

  task automatic check(string req, logic gt, logic [4:0] gi, logic et, logic [4:0] ei);
    n_chk++;
    if (gt !== et || gi !== ei) begin
      n_err++;
      $display("FAIL %s: take=%0b id=%0d expected take=%0b id=%0d", req, gt, gi, et, ei);
    end
  endtask

  task automatic run(string req, logic [31:0] p, logic [31:0] e, logic [31:0] d,
                     logic [1:0] pr, logic mi, logic si,
                     logic et, logic [4:0] ei, logic et8, logic [4:0] ei8);
    logic       pt;
    logic [4:0] pi;
    @(negedge clk);
    pt = take0; pi = id0;
    pend = p; en = e; deleg = d; priv = pr; mie = mi; sie = si;
    #1;
    check({req, " narrow"}, take1, {2'b00, id1}, et8, ei8);
    check({req, " R8 hold"}, take0, id0, pt, pi);
    @(posedge clk); #1;
    check({req, " wide"}, take0, id0, et, ei);
  endtask

  initial begin
    pend = 32'h1; en = 32'h1;
    repeat (3) @(posedge clk);
    #1;
    check("R9 reset", take0, id0, 1'b0, 5'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    run("R1 R7 masked", 32'h10, 32'h0F, 0, 2'd0, 0, 0, 0, 0, 0, 0);
    run("R2 S no mie", 32'h04, 32'h04, 0, 2'd1, 0, 0, 1, 2, 1, 2);
    run("R2 M mie", 32'h4000_0080, 32'h4000_0080, 0, 2'd3, 1, 0, 1, 7, 1, 7);
    run("R3 M closed", 32'hFF, 32'hFF, 0, 2'd3, 0, 1, 0, 0, 0, 0);
    run("R4 U deleg", 32'h20, 32'h20, 32'h20, 2'd0, 0, 0, 1, 5, 1, 5);
    run("R4 S sie", 32'h20, 32'h20, 32'h20, 2'd1, 0, 1, 1, 5, 1, 5);
    run("R5 S no sie", 32'h20, 32'h20, 32'h20, 2'd1, 1, 0, 0, 0, 0, 0);
    run("R5 M deleg", 32'h20, 32'h20, 32'h20, 2'd3, 1, 1, 0, 0, 0, 0);
    run("R6 mixed", 32'h106, 32'h106, 32'h02, 2'd1, 0, 0, 1, 2, 1, 2);
    run("R6 high", 32'h8000_0100, 32'h8000_0100, 0, 2'd0, 0, 0, 1, 8, 0, 0);
    run("R6 top", 32'h8000_0000, 32'hFFFF_FFFF, 0, 2'd0, 0, 0, 1, 31, 0, 0);
    run("R6 deleg low", 32'h0C, 32'h0C, 32'h04, 2'd0, 0, 0, 1, 2, 1, 2);
    run("R10 rsv", 32'h03, 32'h03, 32'h01, 2'd2, 0, 1, 1, 1, 1, 1);
    run("R7 idle", 0, 32'hFFFF_FFFF, 0, 2'd0, 1, 1, 0, 0, 0, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: timeout expired, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule